// File: doc/BRIEF.md
# Audio Period Ring Transfer Controller

This block holds the control and status state for one direction of an audio memory transfer engine. Software places a ring buffer in memory and splits it into a programmed number of equal periods. It then sets the 64-bit base address and starts the channel. Each time the stream datapath moves one beat, it pulses an advance strobe. While the channel is running, the block then moves its byte position forward, wraps the position at the end of the ring, and gives the datapath the memory address for the next beat.

At every period boundary the block sets a completion flag. The flag drives an interrupt line when its enable bit is set, and software clears it by writing 1 to it. Software can read the current byte position at any time, which lets it track playback or capture progress. A soft-reset bit clears the live state of the channel and then clears itself, so software can poll for completion. The sample width, channel count, bytes-per-channel and timeout-enable settings are only stored for the datapath and read back.

Top module: `aud_ring_dma_ctl`

## Requirements
- R1: After rst_n is released, every register reads 0, irq and dma_run are 0, and mem_addr is 0.
- R2: The control register at offset 0x10 stores run in bit 0, completion-interrupt enable in bit 13, timeout enable in bit 14, the sample-width code in bits [18:16] and the channel count in bits [19+CH_W-1:19]. All of these fields read back as written, and dma_run follows bit 0.
- R3: Writing 1 to control bit 1 makes that bit read 1 for exactly one cycle. At the next clock edge the position, the run bit and the completion flag clear, bit 1 reads 0 again, and the other control fields keep their values.
- R4: On each cycle with beat_adv high and run set, the position increases by BEAT_BYTES. When run is clear, beat_adv has no effect on the position or on mem_addr.
- R5: When the next position would reach periods × period-bytes, the position wraps to 0.
- R6: Offset 0x28 reads the position. A stored count at or above the current ring size (periods × period-bytes) reads as 0. mem_addr equals the 64-bit base ({0x24 word, 0x20 word}) plus that position, and carries from the low word into the high word.
- R7: Status bit 31 at offset 0x14 is set whenever an advance completes a period or ends the ring. Writing 1 to it clears it, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R8: irq is the completion flag ANDed with control bit 13. With REG_IRQ=1 it is registered, so it lags both inputs by one cycle.
- R9: Offset 0x1C (periods in [31:16], period bytes in [15:0]), 0x20, 0x24 and 0x44 store full 32-bit words and read them back.
- R10: Offsets outside the map read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| beat_adv | input | 1 | One beat moved by the datapath |
| dma_run | output | 1 | Channel enabled |
| mem_addr | output | 64 | Address of the next beat |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with BEAT_BYTES=64 and REG_IRQ=1. With 64-byte beats, a 192-byte period takes three strobes and a two-period ring takes six. This makes period crossings, ring wraps, a boundary that coincides with a clear, and a position left beyond a shrunken ring all reachable in a few cycles. REG_IRQ=1 exercises the registered interrupt variant, whose one-cycle lag the bench checks both when the interrupt rises and when it falls. A base address just below a 32-bit boundary checks the carry into the high word.

// File: rtl/ard_pkg.sv
package ard_pkg;
   // register byte offsets within one channel
   localparam logic [7:0] OFS_CTRL   = 8'h10;
   localparam logic [7:0] OFS_STAT   = 8'h14;
   localparam logic [7:0] OFS_PERIOD = 8'h1C;
   localparam logic [7:0] OFS_BASELO = 8'h20;
   localparam logic [7:0] OFS_BASEHI = 8'h24;
   localparam logic [7:0] OFS_POS    = 8'h28;
   localparam logic [7:0] OFS_BPC    = 8'h44;

   // control field positions
   localparam int CTL_RUN   = 0;
   localparam int CTL_SRST  = 1;
   localparam int CTL_IOCEN = 13;
   localparam int CTL_TOEN  = 14;
   localparam int CTL_WID   = 16;
   localparam int CTL_CH    = 19;

   // status field positions
   localparam int STS_DONE  = 31;
endpackage

// File: rtl/ard_regs.sv
module ard_regs
   import ard_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int CH_W   = 4,
   parameter int CNT_W  = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              period_evt,
   input  logic [CNT_W-1:0]  pos,
   output logic              run,
   output logic              srst,
   output logic              ioc_en,
   output logic              done_flag,
   output logic [15:0]       nper,
   output logic [15:0]       pbytes,
   output logic [63:0]       base
);
   localparam int WID_W = 3;

   logic             run_q, srst_q, iocen_q, toen_q, done_q;
   logic [WID_W-1:0] wid_q;
   logic [CH_W-1:0]  ch_q;
   logic [31:0]      period_q, baselo_q, basehi_q, bpc_q;

   logic wr_ctrl, wr_stat, wr_period, wr_lo, wr_hi, wr_bpc;

   always_comb begin
      wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
      wr_stat   = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
      wr_period = bus_wr && (bus_addr == ADDR_W'(OFS_PERIOD));
      wr_lo     = bus_wr && (bus_addr == ADDR_W'(OFS_BASELO));
      wr_hi     = bus_wr && (bus_addr == ADDR_W'(OFS_BASEHI));
      wr_bpc    = bus_wr && (bus_addr == ADDR_W'(OFS_BPC));
   end

   // control word: soft reset wins over a run write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         srst_q  <= 1'b0;
         iocen_q <= 1'b0;
         toen_q  <= 1'b0;
         wid_q   <= '0;
         ch_q    <= '0;
      end else begin
         srst_q <= wr_ctrl && bus_wdata[CTL_SRST];
         if (srst_q)
            run_q <= 1'b0;
         else if (wr_ctrl)
            run_q <= bus_wdata[CTL_RUN];
         if (wr_ctrl) begin
            iocen_q <= bus_wdata[CTL_IOCEN];
            toen_q  <= bus_wdata[CTL_TOEN];
            wid_q   <= bus_wdata[CTL_WID +: WID_W];
            ch_q    <= bus_wdata[CTL_CH +: CH_W];
         end
      end
   end

   // completion flag: set beats write-one-to-clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         done_q <= 1'b0;
      else if (srst_q)
         done_q <= 1'b0;
      else if (period_evt)
         done_q <= 1'b1;
      else if (wr_stat && bus_wdata[STS_DONE])
         done_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         baselo_q <= '0;
         basehi_q <= '0;
         bpc_q    <= '0;
      end else begin
         if (wr_period) period_q <= bus_wdata;
         if (wr_lo)     baselo_q <= bus_wdata;
         if (wr_hi)     basehi_q <= bus_wdata;
         if (wr_bpc)    bpc_q    <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_CTRL)) begin
         bus_rdata[CTL_RUN]          = run_q;
         bus_rdata[CTL_SRST]         = srst_q;
         bus_rdata[CTL_IOCEN]        = iocen_q;
         bus_rdata[CTL_TOEN]         = toen_q;
         bus_rdata[CTL_WID +: WID_W] = wid_q;
         bus_rdata[CTL_CH +: CH_W]   = ch_q;
      end else if (bus_addr == ADDR_W'(OFS_STAT))
         bus_rdata[STS_DONE] = done_q;
      else if (bus_addr == ADDR_W'(OFS_PERIOD))
         bus_rdata = period_q;
      else if (bus_addr == ADDR_W'(OFS_BASELO))
         bus_rdata = baselo_q;
      else if (bus_addr == ADDR_W'(OFS_BASEHI))
         bus_rdata = basehi_q;
      else if (bus_addr == ADDR_W'(OFS_POS))
         bus_rdata = 32'(pos);
      else if (bus_addr == ADDR_W'(OFS_BPC))
         bus_rdata = bpc_q;
   end

   assign run       = run_q;
   assign srst      = srst_q;
   assign ioc_en    = iocen_q;
   assign done_flag = done_q;
   assign nper      = period_q[31:16];
   assign pbytes    = period_q[15:0];
   assign base      = {basehi_q, baselo_q};
endmodule

// File: rtl/ard_pos.sv
module ard_pos #(
   parameter int CNT_W      = 20,
   parameter int BEAT_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst,
   input  logic             step,
   input  logic [15:0]      nper,
   input  logic [15:0]      pbytes,
   output logic [CNT_W-1:0] pos,
   output logic             period_evt
);
   localparam int OFS_W = 17;
   localparam logic [CNT_W:0]   BEAT_C = (CNT_W+1)'(BEAT_BYTES);
   localparam logic [OFS_W-1:0] BEAT_O = OFS_W'(BEAT_BYTES);

   logic [CNT_W-1:0] cnt_q;
   logic [OFS_W-1:0] ofs_q;
   logic [31:0]      ring;
   logic [CNT_W:0]   cnt_inc;
   logic [OFS_W-1:0] ofs_inc;
   logic             ring_end, per_end;

   always_comb begin
      ring       = 32'(nper) * 32'(pbytes);
      cnt_inc    = {1'b0, cnt_q} + BEAT_C;
      ofs_inc    = ofs_q + BEAT_O;
      ring_end   = 32'(cnt_inc) >= ring;
      per_end    = ofs_inc >= {1'b0, pbytes};
      period_evt = step && !srst && (ring_end || per_end);
      pos        = (32'(cnt_q) >= ring) ? '0 : cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ofs_q <= '0;
      end else if (srst) begin
         cnt_q <= '0;
         ofs_q <= '0;
      end else if (step) begin
         cnt_q <= ring_end ? '0 : cnt_inc[CNT_W-1:0];
         ofs_q <= (ring_end || per_end) ? '0 : ofs_inc;
      end
   end
endmodule

// File: rtl/ard_irq.sv
module ard_irq #(
   parameter bit REG_IRQ = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   input  logic en,
   output logic irq
);
   generate
      if (REG_IRQ) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= flag && en;
         end
         assign irq = irq_q;
      end else begin : g_comb
         assign irq = flag && en;
      end
   endgenerate
endmodule

// File: rtl/aud_ring_dma_ctl.sv
module aud_ring_dma_ctl #(
   parameter int ADDR_W     = 8,
   parameter int CH_W       = 4,
   parameter int CNT_W      = 20,
   parameter int BEAT_BYTES = 4,
   parameter bit REG_IRQ    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              beat_adv,
   output logic              dma_run,
   output logic [63:0]       mem_addr,
   output logic              irq
);
   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W must cover offsets up to 0x44");
      end
      if (CH_W < 1 || CH_W > 13) begin : g_bad_ch
         $error("CH_W must lie in 1..13");
      end
      if (CNT_W < 17 || CNT_W > 31) begin : g_bad_cnt
         $error("CNT_W must lie in 17..31");
      end
      if (!(BEAT_BYTES inside {1, 2, 4, 8, 16, 32, 64})) begin : g_bad_beat
         $error("BEAT_BYTES must be a power of two not above 64");
      end
   endgenerate

   logic             run_w, srst_w, iocen_w, done_w, evt_w, step_w;
   logic [15:0]      nper_w, pbytes_w;
   logic [63:0]      base_w;
   logic [CNT_W-1:0] pos_w;

   assign step_w = beat_adv && run_w;

   ard_regs #(.ADDR_W(ADDR_W), .CH_W(CH_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .period_evt(evt_w), .pos(pos_w),
      .run(run_w), .srst(srst_w), .ioc_en(iocen_w), .done_flag(done_w),
      .nper(nper_w), .pbytes(pbytes_w), .base(base_w)
   );

   ard_pos #(.CNT_W(CNT_W), .BEAT_BYTES(BEAT_BYTES)) u_pos (
      .clk(clk), .rst_n(rst_n), .srst(srst_w), .step(step_w),
      .nper(nper_w), .pbytes(pbytes_w), .pos(pos_w), .period_evt(evt_w)
   );

   ard_irq #(.REG_IRQ(REG_IRQ)) u_irq (
      .clk(clk), .rst_n(rst_n), .flag(done_w), .en(iocen_w), .irq(irq)
   );

   assign dma_run  = run_w;
   assign mem_addr = base_w + 64'(pos_w);
endmodule

// File: rtl/ard_chk.sv
module ard_chk #(
   parameter int CNT_W   = 20,
   parameter bit REG_IRQ = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srst,
   input logic             run,
   input logic             beat_adv,
   input logic [CNT_W-1:0] pos,
   input logic [15:0]      nper,
   input logic [15:0]      pbytes,
   input logic             flag,
   input logic             ioc_en,
   input logic             irq
);
   logic [31:0] ring_c;
   assign ring_c = 32'(nper) * 32'(pbytes);

   assert_srst_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !srst);

   assert_srst_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (!run && pos == '0 && !flag));

   // R4: no accepted beat and no reset -> position held unless config moved
   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!(beat_adv && run) && !srst) |=>
         (!($stable(nper) && $stable(pbytes)) || $stable(pos)));

   assert_pos_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pos == '0) || (32'(pos) < ring_c));

   assert_flag_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(beat_adv && run));

   generate
      if (REG_IRQ) begin : g_reg
         assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> $past(flag && ioc_en));
      end else begin : g_comb
         assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq |-> (flag && ioc_en));
      end
   endgenerate
endmodule

bind aud_ring_dma_ctl ard_chk #(.CNT_W(CNT_W), .REG_IRQ(REG_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .srst(srst_w), .run(run_w), .beat_adv(beat_adv),
   .pos(pos_w), .nper(nper_w), .pbytes(pbytes_w), .flag(done_w),
   .ioc_en(iocen_w), .irq(irq)
);

// File: tb/sim_aud_ring_dma_ctl.sv
module sim_aud_ring_dma_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int BEAT = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        beat_adv = 1'b0;
   logic        dma_run;
   logic [63:0] mem_addr;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   aud_ring_dma_ctl #(.ADDR_W(8), .CH_W(4), .CNT_W(20), .BEAT_BYTES(BEAT), .REG_IRQ(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .beat_adv(beat_adv),
      .dma_run(dma_run), .mem_addr(mem_addr), .irq(irq)
   );

   // {expected position, expected flag, beats to issue}
   localparam logic [31:0] VEC [8] = '{
      {16'd64,  8'd0, 8'd1}, {16'd128, 8'd0, 8'd1}, {16'd192, 8'd1, 8'd1},
      {16'd320, 8'd0, 8'd2}, {16'd0,   8'd1, 8'd1}, {16'd256, 8'd1, 8'd4},
      {16'd0,   8'd1, 8'd2}, {16'd0,   8'd0, 8'd0}
   };

   localparam logic [31:0] CTRL_V = 32'h0013_6001;
   localparam logic [63:0] BASE_V = 64'h0000_0001_FFFF_FF00;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic beats(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); beat_adv = 1'b1;
         @(negedge clk); beat_adv = 1'b0;
      end
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h10, d); chk("R1 ctrl", d, 0);
      rd(8'h14, d); chk("R1 status", d, 0);
      rd(8'h28, d); chk("R1 position", d, 0);
      rd(8'h1C, d); chk("R1 period", d, 0);
      chk("R1 irq", irq, 0);
      chk("R1 dma_run", dma_run, 0);
      chk("R1 mem_addr", mem_addr, 0);

      // R9 storage
      wr(8'h1C, {16'd2, 16'd192});
      wr(8'h44, 32'd96);
      wr(8'h20, BASE_V[31:0]);
      wr(8'h24, BASE_V[63:32]);
      rd(8'h1C, d); chk("R9 period", d, {16'd2, 16'd192});
      rd(8'h44, d); chk("R9 bytes per channel", d, 96);
      rd(8'h20, d); chk("R9 base low", d, BASE_V[31:0]);
      rd(8'h24, d); chk("R9 base high", d, BASE_V[63:32]);

      // R10 unmapped
      wr(8'h30, 32'hDEAD_BEEF);
      rd(8'h30, d); chk("R10 unmapped read", d, 0);
      rd(8'h04, d); chk("R10 other unmapped", d, 0);
      rd(8'h1C, d); chk("R10 period untouched", d, {16'd2, 16'd192});
      rd(8'h10, d); chk("R10 ctrl untouched", d, 0);

      // R2 control fields
      wr(8'h10, CTRL_V);
      rd(8'h10, d); chk("R2 ctrl readback", d, CTRL_V);
      chk("R2 dma_run", dma_run, 1);

      // R4 R5 R7 vector walk
      for (int k = 0; k < 8; k++) begin
         beats(int'(VEC[k][7:0]));
         rd(8'h28, d); chk("R4 R5 position", d, 32'(VEC[k][31:16]));
         rd(8'h14, d); chk("R7 flag", d[31], VEC[k][8]);
         if (VEC[k][8]) begin
            wr(8'h14, 32'h8000_0000);
            rd(8'h14, d); chk("R7 write-one clear", d[31], 0);
         end
      end

      // R8 registered irq
      beats(3);
      chk("R8 irq lags flag", irq, 0);
      @(negedge clk);
      chk("R8 irq raised", irq, 1);
      wr(8'h14, 32'h0);
      rd(8'h14, d); chk("R7 write zero keeps flag", d[31], 1);
      wr(8'h10, CTRL_V & ~32'h2000);
      chk("R8 irq one cycle after disable", irq, 1);
      @(negedge clk);
      chk("R8 irq masked", irq, 0);
      rd(8'h14, d); chk("R8 flag kept while masked", d[31], 1);
      wr(8'h10, CTRL_V);
      wr(8'h14, 32'h8000_0000);

      // R6 address with carry
      chk("R6 mem_addr 192", mem_addr, BASE_V + 64'd192);
      beats(1);
      chk("R6 mem_addr carry", mem_addr, 64'h0000_0002_0000_0000);

      // R4 ignored when stopped
      wr(8'h10, CTRL_V & ~32'h1);
      beats(3);
      rd(8'h28, d); chk("R4 stopped position", d, 256);
      chk("R4 stopped mem_addr", mem_addr, 64'h0000_0002_0000_0000);
      wr(8'h10, CTRL_V);

      // R7 set wins over clear
      beats(1);
      @(negedge clk);
      beat_adv = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h8000_0000; bus_wr = 1'b1;
      @(negedge clk);
      beat_adv = 1'b0; bus_wr = 1'b0;
      rd(8'h14, d); chk("R7 set wins", d[31], 1);
      rd(8'h28, d); chk("R5 wrap with clear", d, 0);
      wr(8'h14, 32'h8000_0000);

      // R6 clamp past a shrunken ring
      beats(5);
      wr(8'h14, 32'h8000_0000);
      wr(8'h1C, {16'd1, 16'd192});
      rd(8'h28, d); chk("R6 clamp read", d, 0);
      chk("R6 clamp mem_addr", mem_addr, BASE_V);
      wr(8'h1C, {16'd2, 16'd192});
      rd(8'h28, d); chk("R6 restored position", d, 320);

      // R3 soft reset
      beats(2);
      rd(8'h28, d); chk("R5 before reset", d, 64);
      wr(8'h10, CTRL_V | 32'h2);
      rd(8'h10, d); chk("R3 reset bit visible", d, CTRL_V | 32'h2);
      @(negedge clk);
      rd(8'h10, d); chk("R3 reset bit cleared", d, CTRL_V & ~32'h1);
      rd(8'h28, d); chk("R3 position cleared", d, 0);
      rd(8'h14, d); chk("R3 flag cleared", d, 0);
      chk("R3 run cleared", dma_run, 0);
      rd(8'h1C, d); chk("R3 period kept", d, {16'd2, 16'd192});

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule